// File: doc/BRIEF.md
# MII Transmit Nibble Interface

This block sends a frame onto a 4-bit media-independent transmit interface. An upstream source supplies the frame as a byte stream with valid, last and ready. The frame already contains its preamble and CRC. The block splits each byte into two nibbles and drives them with a transmit-enable. All of these outputs change on the rising edge of the transmit clock. The interface takes at most one byte every two transmit clocks.

A collision line can arrive at any time, with no relation to any clock. It passes through a synchronizer clocked by the transmit-side clock and is reported in two forms: a live flag, and a sticky flag that is cleared by a pulse. The transmit clock comes from the attached physical-layer device, so it cannot be trusted to run. A watchdog clocked by an internal clock checks for its edges. It drives a select output that chooses between the internal clock and the transmit clock. An external multiplexer uses that select to form `core_clk`, which clocks the data path and the collision logic. While reset is asserted the select picks the internal clock, so reset never depends on the transmit clock.

Top module: `mii_tx_nibble_if`

## Requirements
- R1: Every byte accepted from upstream goes out as two nibbles on consecutive `core_clk` cycles, low nibble (byte bits 3:0) first and high nibble (bits 7:4) second. `txd[0]` carries the least significant bit of each nibble.
- R2: `s_ready` is high only in the high-nibble cycle, so a handshake happens at most once every two `core_clk` cycles. The source holds `s_data` and `s_last` stable while `s_valid` is high and `s_ready` is low.
- R3: `tx_en` is high in every cycle that carries a nibble of the frame. It falls in the cycle after the high nibble of the byte marked `s_last`. At least one idle cycle follows every frame, even when the next byte is already waiting.
- R4: If `s_valid` is low when a low-nibble slot comes up, `tx_en` drops. The frame ends after the nibble already sent, and a later byte starts a new burst.
- R5: In reset and right after it, `tx_en`, `txd`, `s_ready`, `col_sync` and `col_seen` are 0, and `use_int_clk` is 1.
- R6: `col_in` passes through two flip-flop stages on `core_clk`. A change that is applied just after a rising edge shows on `col_sync` after the second rising edge, not after the first.
- R7: `col_seen` is set by `col_sync` and stays set after `col_in` returns low. A `col_clr` pulse clears it. If `col_clr` and `col_sync` are both high in the same cycle, the set wins.
- R8: Once the watchdog is selecting the internal clock, it switches `use_int_clk` to 0 after seeing `GOOD_EDGES` (8) transmit-clock edges in a row, where each edge comes within the timeout window of the one before.
- R9: When no transmit-clock edge is seen for `LOSS_CYCLES` (64) internal-clock cycles, `use_int_clk` returns to 1. It does not switch before that window has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_clk | input | 1 | Internal free-running clock; clocks the watchdog |
| mii_tx_clk | input | 1 | Raw transmit clock from the physical-layer device; observed only |
| core_clk | input | 1 | Clock chosen by the external multiplexer using `use_int_clk` |
| rst_n | input | 1 | Synchronous active-low reset |
| s_data | input | 8 | Upstream byte |
| s_valid | input | 1 | Upstream byte valid |
| s_last | input | 1 | Upstream byte is the last byte of the frame |
| s_ready | output | 1 | Byte accepted at the next rising edge of `core_clk` |
| tx_en | output | 1 | Transmit enable |
| txd | output | 4 | Transmit nibble; bit 0 is the LSB |
| col_in | input | 1 | Asynchronous collision indication |
| col_clr | input | 1 | Clears the sticky collision flag |
| col_sync | output | 1 | Synchronized collision |
| col_seen | output | 1 | Sticky collision flag |
| use_int_clk | output | 1 | 1 selects the internal clock, 0 selects the transmit clock |

## Verification
The bench builds the block with its defaults: a 64-cycle loss window, 8 edges to recover, and a 2-stage synchronizer. The transmit clock runs at 25 MHz against a 200 MHz internal clock, so one transmit period is eight internal cycles. That keeps the recovery count well inside the loss window. It also lets the bench stop the clock and probe both sides of the 64-cycle boundary within a few hundred cycles. With two synchronizer stages, the latency of the collision path can be checked edge by edge.

// File: rtl/mii_tx_pkg.sv
// Package: shared widths and types for the MII transmit nibble interface.
// Assumes: a byte is eight bits and the media side is four bits wide.
package mii_tx_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    typedef logic [NIB_W-1:0]  nibble_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Which half of the current byte goes out at the next edge.
    typedef enum logic {
        SLOT_LO = 1'b0,
        SLOT_HI = 1'b1
    } slot_e;
endpackage

// File: rtl/mii_tx_sync.sv
// Module: multi-stage synchronizer for one asynchronous bit.
// Assumes: the input has no relation to clk; the output is valid STAGES
// rising edges after the input settles. Synchronous active-low reset to 0.
module mii_tx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Purpose: first capture of the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_rest
                // Purpose: extra settling stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mii_tx_clk_watch.sv
// Module: watchdog for the transmit clock, running on the internal clock.
// Assumes: the internal clock is at least four times faster than the
// transmit clock. It samples the transmit clock through a synchronizer and
// counts cycles between rising edges. Reset selects the internal clock.
module mii_tx_clk_watch #(
    parameter int LOSS_CYCLES = 64,
    parameter int GOOD_EDGES  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic int_clk,
    input  logic rst_n,
    input  logic tx_clk_raw,
    output logic use_int_clk
);
    localparam int GAP_W  = $clog2(LOSS_CYCLES + 1);
    localparam int GOOD_W = $clog2(GOOD_EDGES + 1);

    logic              smp;
    logic              smp_prev_q;
    logic              edge_seen;
    logic [GAP_W-1:0]  gap_q;
    logic [GOOD_W-1:0] good_q;
    logic              use_int_q;

    mii_tx_sync #(.STAGES(SYNC_STAGES)) u_clk_sample (
        .clk     (int_clk),
        .rst_n   (rst_n),
        .d_async (tx_clk_raw),
        .q_sync  (smp)
    );

    // Purpose: flag a rising edge of the sampled transmit clock.
    always_comb edge_seen = smp & ~smp_prev_q;

    // Purpose: count the gap since the last edge, count good edges, pick the clock.
    always_ff @(posedge int_clk) begin
        if (!rst_n) begin
            smp_prev_q <= 1'b0;
            gap_q      <= '0;
            good_q     <= '0;
            use_int_q  <= 1'b1;
        end else begin
            smp_prev_q <= smp;
            if (edge_seen) begin
                gap_q <= '0;
                if (use_int_q) begin
                    if (good_q == GOOD_W'(GOOD_EDGES - 1)) begin
                        use_int_q <= 1'b0;
                        good_q    <= '0;
                    end else begin
                        good_q <= good_q + 1'b1;
                    end
                end
            end else if (gap_q == GAP_W'(LOSS_CYCLES - 1)) begin
                use_int_q <= 1'b1;
                good_q    <= '0;
            end else begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    assign use_int_clk = use_int_q;
endmodule

// File: rtl/mii_tx_col_monitor.sv
// Module: collision synchronizer with a sticky flag.
// Assumes: col_in is asynchronous; col_clr is synchronous to clk.
// When col_clr and the synchronized collision are both high, the set wins.
module mii_tx_col_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic col_in,
    input  logic col_clr,
    output logic col_sync,
    output logic col_seen
);
    logic col_s;
    logic seen_q;

    mii_tx_sync #(.STAGES(SYNC_STAGES)) u_col_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (col_in),
        .q_sync  (col_s)
    );

    // Purpose: hold a collision until software-side logic clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)       seen_q <= 1'b0;
        else if (col_s)   seen_q <= 1'b1;
        else if (col_clr) seen_q <= 1'b0;
    end

    assign col_sync = col_s;
    assign col_seen = seen_q;
endmodule

// File: rtl/mii_tx_nibble_path.sv
// Module: byte-to-nibble transmit data path.
// Assumes: the upstream source holds data and last while valid is high and
// ready is low. It looks at the byte in the low-nibble slot and accepts it
// in the high-nibble slot. A gap in valid at a low slot ends the frame.
module mii_tx_nibble_path
    import mii_tx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  byte_t   s_data,
    input  logic    s_valid,
    input  logic    s_last,
    output logic    s_ready,
    output logic    tx_en,
    output nibble_t txd
);
    slot_e   slot_q;
    logic    end_q;
    logic    en_q;
    nibble_t nib_q;

    // Purpose: accept the byte only in the high-nibble slot.
    always_comb s_ready = (slot_q == SLOT_HI);

    // Purpose: send nibbles, end a frame, force one idle cycle after last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_LO;
            end_q  <= 1'b0;
            en_q   <= 1'b0;
            nib_q  <= '0;
        end else if (slot_q == SLOT_HI) begin
            nib_q  <= s_data[BYTE_W-1:NIB_W];
            en_q   <= 1'b1;
            end_q  <= s_last;
            slot_q <= SLOT_LO;
        end else if (s_valid && !end_q) begin
            nib_q  <= s_data[NIB_W-1:0];
            en_q   <= 1'b1;
            slot_q <= SLOT_HI;
        end else begin
            nib_q <= '0;
            en_q  <= 1'b0;
            end_q <= 1'b0;
        end
    end

    assign tx_en = en_q;
    assign txd   = nib_q;
endmodule

// File: rtl/mii_tx_nibble_if.sv
// Module: top of the MII transmit nibble interface.
// Assumes: core_clk comes from an external multiplexer driven by
// use_int_clk (1 = int_clk, 0 = mii_tx_clk). rst_n is held for several
// int_clk cycles so the select settles on the internal clock.
module mii_tx_nibble_if #(
    parameter int LOSS_CYCLES = 64,
    parameter int GOOD_EDGES  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       int_clk,
    input  logic       mii_tx_clk,
    input  logic       core_clk,
    input  logic       rst_n,
    input  logic [7:0] s_data,
    input  logic       s_valid,
    input  logic       s_last,
    output logic       s_ready,
    output logic       tx_en,
    output logic [3:0] txd,
    input  logic       col_in,
    input  logic       col_clr,
    output logic       col_sync,
    output logic       col_seen,
    output logic       use_int_clk
);
    mii_tx_clk_watch #(
        .LOSS_CYCLES (LOSS_CYCLES),
        .GOOD_EDGES  (GOOD_EDGES),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_watch (
        .int_clk     (int_clk),
        .rst_n       (rst_n),
        .tx_clk_raw  (mii_tx_clk),
        .use_int_clk (use_int_clk)
    );

    mii_tx_nibble_path u_path (
        .clk     (core_clk),
        .rst_n   (rst_n),
        .s_data  (s_data),
        .s_valid (s_valid),
        .s_last  (s_last),
        .s_ready (s_ready),
        .tx_en   (tx_en),
        .txd     (txd)
    );

    mii_tx_col_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_col (
        .clk      (core_clk),
        .rst_n    (rst_n),
        .col_in   (col_in),
        .col_clr  (col_clr),
        .col_sync (col_sync),
        .col_seen (col_seen)
    );
endmodule

// File: rtl/mii_tx_nibble_if_chk.sv
// Module: property checker bound to mii_tx_nibble_if.
// Assumes: the same port names as the top module; observes only.
module mii_tx_nibble_if_chk (
    input logic       int_clk,
    input logic       core_clk,
    input logic       rst_n,
    input logic [7:0] s_data,
    input logic       s_valid,
    input logic       s_last,
    input logic       s_ready,
    input logic       tx_en,
    input logic [3:0] txd,
    input logic       col_sync,
    input logic       col_seen,
    input logic       use_int_clk
);
    assert_hi_nibble_R1: assert property (@(posedge core_clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> (tx_en && txd == $past(s_data[7:4])));

    assert_lo_nibble_R1: assert property (@(posedge core_clk) disable iff (!rst_n)
        $rose(tx_en) |-> (txd == $past(s_data[3:0])));

    assert_ready_spacing_R2: assert property (@(posedge core_clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> !s_ready);

    assert_frame_end_R3: assert property (@(posedge core_clk) disable iff (!rst_n)
        (s_valid && s_ready && s_last) |=> ##1 !tx_en);

    assert_sticky_set_R7: assert property (@(posedge core_clk) disable iff (!rst_n)
        col_sync |=> col_seen);

    assert_reset_int_clk_R5: assert property (@(posedge int_clk)
        !rst_n |=> use_int_clk);
endmodule

bind mii_tx_nibble_if mii_tx_nibble_if_chk u_chk (.*);

// File: tb/tb_mii_tx_nibble_if.sv
`timescale 1ns/1ps
module tb_mii_tx_nibble_if;
    logic       int_clk = 1'b0;
    logic       mii_tx_clk = 1'b0;
    logic       tx_run = 1'b0;
    logic       core_clk;
    logic       rst_n = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_valid = 1'b0;
    logic       s_last = 1'b0;
    logic       s_ready;
    logic       tx_en;
    logic [3:0] txd;
    logic       col_in = 1'b0;
    logic       col_clr = 1'b0;
    logic       col_sync;
    logic       col_seen;
    logic       use_int_clk;

    int checks = 0;
    int failures = 0;
    int ready_bad = 0;
    bit mon_on = 1'b0;
    bit want_idle = 1'b0;
    logic [3:0] exp_nib[$];
    bit         exp_end[$];

    always #2.5 int_clk = ~int_clk;
    initial forever begin
        #20;
        if (tx_run) mii_tx_clk = ~mii_tx_clk;
    end
    assign core_clk = use_int_clk ? int_clk : mii_tx_clk;

    mii_tx_nibble_if dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: presents one byte, waits for its handshake, queues the expected nibbles.
    task automatic send_byte(input logic [7:0] b, input bit last, input bit ends);
        bit r;
        exp_nib.push_back(b[3:0]); exp_end.push_back(1'b0);
        exp_nib.push_back(b[7:4]); exp_end.push_back(last || ends);
        @(negedge core_clk);
        s_data = b; s_last = last; s_valid = 1'b1;
        forever begin
            r = s_ready;
            @(posedge core_clk);
            if (r) break;
            @(negedge core_clk);
        end
    endtask

    task automatic go_idle(input int n);
        @(negedge core_clk);
        s_valid = 1'b0; s_last = 1'b0;
        repeat (n) @(negedge core_clk);
    endtask

    // Monitor: pops the expected nibbles and compares them with the pins (R1, R3, R4).
    always @(negedge core_clk) begin
        if (mon_on) begin
            if (s_ready && !tx_en) ready_bad++;
            if (want_idle) begin
                check(!tx_en, "R3/R4 idle after frame end", tx_en, 0);
                want_idle = 1'b0;
            end else if (tx_en) begin
                if (exp_nib.size() == 0) begin
                    check(1'b0, "R3 unexpected tx_en", txd, 0);
                end else begin
                    automatic logic [3:0] e = exp_nib.pop_front();
                    automatic bit l = exp_end.pop_front();
                    check(txd == e, "R1 nibble value/order", txd, e);
                    if (l) want_idle = 1'b1;
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge int_clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (10) @(posedge int_clk);
        #1;
        // R5: reset state with no transmit clock present
        check(tx_en == 0 && txd == 0, "R5 reset tx outputs", {tx_en, txd}, 0);
        check(s_ready == 0, "R5 reset ready", s_ready, 0);
        check(use_int_clk == 1, "R5 reset selects internal clock", use_int_clk, 1);
        check(col_sync == 0 && col_seen == 0, "R5 reset collision flags", {col_sync, col_seen}, 0);
        @(negedge int_clk); rst_n = 1'b1;
        repeat (100) @(posedge int_clk);
        #1 check(use_int_clk == 1, "R9 stays internal without transmit clock", use_int_clk, 1);

        // R8: recovery after consecutive edges
        tx_run = 1'b1;
        repeat (7) @(posedge mii_tx_clk);
        #1 check(use_int_clk == 1, "R8 not before 8 edges", use_int_clk, 1);
        repeat (5) @(posedge mii_tx_clk);
        #1 check(use_int_clk == 0, "R8 switched to transmit clock", use_int_clk, 0);

        // R9: loss detection window
        tx_run = 1'b0;
        repeat (40) @(posedge int_clk);
        #1 check(use_int_clk == 0, "R9 no early fallback", use_int_clk, 0);
        repeat (40) @(posedge int_clk);
        #1 check(use_int_clk == 1, "R9 fallback after loss window", use_int_clk, 1);
        tx_run = 1'b1;
        repeat (14) @(posedge mii_tx_clk);
        #1 check(use_int_clk == 0, "R8 recovered again", use_int_clk, 0);

        // R6/R7: collision path on the transmit clock
        @(negedge core_clk); col_in = 1'b1;
        @(negedge core_clk);
        check(col_sync == 0, "R6 not visible after one edge", col_sync, 0);
        @(negedge core_clk);
        check(col_sync == 1, "R6 visible after two edges", col_sync, 1);
        col_in = 1'b0;
        repeat (3) @(negedge core_clk);
        check(col_sync == 0 && col_seen == 1, "R7 sticky holds", {col_sync, col_seen}, 1);
        col_clr = 1'b1;
        @(negedge core_clk); col_clr = 1'b0;
        check(col_seen == 0, "R7 cleared by pulse", col_seen, 0);
        col_in = 1'b1;
        repeat (3) @(negedge core_clk);
        col_clr = 1'b1;
        repeat (2) @(negedge core_clk);
        check(col_seen == 1, "R7 set wins over clear", col_seen, 1);
        col_clr = 1'b0; col_in = 1'b0;
        repeat (3) @(negedge core_clk);
        col_clr = 1'b1;
        @(negedge core_clk); col_clr = 1'b0;
        check(col_seen == 0, "R7 clear after collision ends", col_seen, 0);

        // Data path: several frames, back to back, and an underrun (R1-R4)
        mon_on = 1'b1;
        send_byte(8'h55, 1'b0, 1'b0);
        send_byte(8'hD5, 1'b0, 1'b0);
        send_byte(8'hA7, 1'b0, 1'b0);
        send_byte(8'h3C, 1'b1, 1'b0);
        send_byte(8'h0F, 1'b0, 1'b0);
        send_byte(8'hF0, 1'b1, 1'b0);
        go_idle(4);
        send_byte(8'h81, 1'b0, 1'b1);
        go_idle(3);
        send_byte(8'h96, 1'b0, 1'b0);
        send_byte(8'hE2, 1'b1, 1'b0);
        go_idle(2);
        for (int i = 0; i < 16; i++) send_byte(8'(i * 17 + 3), i == 15, 1'b0);
        go_idle(6);
        mon_on = 1'b0;
        check(exp_nib.size() == 0, "R3 all nibbles sent", exp_nib.size(), 0);
        check(ready_bad == 0, "R2 ready only in high slot", ready_bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule